// File: doc/BRIEF.md
# Prioritised Interrupt Source Controller

This block collects a set of level-sensitive interrupt lines and turns them into one external interrupt request for a processor core or for an interrupt presentation stage. Each line has its own register, reached over a simple 32-bit register bus, and that register holds the line's priority. Priorities are nominally 8 bits wide. Only the low `PRIO_W` bits are stored, and `PRIO_W` is 3 by default. If all of the stored bits are ones, the source is masked.

Each cycle the controller considers every line that is both asserted and unmasked. It picks the one with the numerically smallest priority, and a tie goes to the lowest line index. The request output and the winning priority are registered. Software finds out how many priority bits are implemented by reading a read-only configuration word at offset 0. Acknowledge, end-of-interrupt, current-priority filtering and inter-processor interrupts belong to the presentation stage and are not part of this block.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset every source is masked. `irq_req` is 0, `irq_prio` is 0xFF, and a read of any source register returns 0x000000FF.
- R2: The word at byte offset 0x00 is read-only. It returns `PRIO_W` in bits [7:0] and zero in bits [31:8]. Writes to it have no effect.
- R3: The register of source n sits at byte offset 4*(n+1). A write stores `wdata[PRIO_W-1:0]`. When the stored value is not all ones, a read returns it zero-extended to 32 bits.
- R4: Writing a value whose low `PRIO_W` bits are all ones (7 by default) masks the source. A read of a masked source returns 0x000000FF.
- R5: Write data bits above `PRIO_W-1` are ignored. For example, writing 0xF5 with `PRIO_W`=3 stores 5.
- R6: `irq_req` is 1 in the cycle after an edge at which at least one asserted input has an unmasked priority. Masked sources never raise it.
- R7: While `irq_req` is 1, `irq_prio` equals the smallest unmasked priority among the asserted inputs, zero-extended to 8 bits. A tie goes to the lowest index.
- R8: While `irq_req` is 0, `irq_prio` is 0xFF.
- R9: Read data appears on `bus_rdata` one clock after the read request and holds until the next read. Offsets past the last source read as 0, and writes to them change nothing.
- R10: Inputs are level-sensitive. Dropping an input, or masking its source, removes its contribution at the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | NUM_SRC | Level interrupt inputs, one per source |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_req | output | 1 | External interrupt request |
| irq_prio | output | 8 | Priority of the winning source, 0xFF when idle |

## Verification
On every cycle the assertions check the following:
- the configuration word reads back correctly;
- masked sources read as 0xFF;
- read data never has bits set above bit 7;
- the idle priority is 0xFF;
- a raised request never carries the masked code;
- a request is never raised without an asserted input one cycle earlier;
- the arbiter's winner is a line that is actually asserted.

Whether the winner is truly the minimum, and whether truncated writes, out-of-range offsets and masking at run time behave as required, shows up only in the bench. The bench does this with a priority table and a series of input patterns.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  // Architected width of a priority field as seen by software.
  localparam int ARCH_PRIO_W = 8;
  // Value returned on the bus and on irq_prio when nothing is selected.
  localparam logic [ARCH_PRIO_W-1:0] PRIO_NONE = 8'hFF;
  // Register bus data width.
  localparam int BUS_W = 32;
  typedef logic [BUS_W-1:0] bus_word_t;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_en,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  bus_word_t                 bus_wdata,
  output bus_word_t                 bus_rdata,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [PRIO_W-1:0] MASK_CODE = '1;

  logic [WORD_W-1:0] word_sel;
  logic              src_hit;
  logic              cfg_hit;
  logic              rd_en;
  logic [NUM_SRC-1:0] wr_sel;
  logic [PRIO_W-1:0] prio_q [NUM_SRC];
  logic [PRIO_W-1:0] prio_d [NUM_SRC];
  bus_word_t         rdata_d;
  bus_word_t         rdata_q;

  assign word_sel = bus_addr[ADDR_W-1:2];
  assign cfg_hit  = (word_sel == '0);
  assign src_hit  = !cfg_hit && (word_sel <= WORD_W'(NUM_SRC));
  assign rd_en    = bus_en && !bus_we;

  // Per-source priority storage with explicit write enables.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign wr_sel[i] = bus_en && bus_we && (word_sel == WORD_W'(i + 1));

    always_comb begin
      prio_d[i] = prio_q[i];
      if (wr_sel[i]) prio_d[i] = bus_wdata[PRIO_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         prio_q[i] <= MASK_CODE;
      else if (wr_sel[i]) prio_q[i] <= prio_d[i];
    end

    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  // Read multiplexer.
  always_comb begin
    rdata_d = '0;
    if (cfg_hit) begin
      rdata_d = BUS_W'(PRIO_W);
    end else if (src_hit) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (word_sel == WORD_W'(i + 1)) begin
          if (prio_q[i] == MASK_CODE) rdata_d = BUS_W'(PRIO_NONE);
          else                        rdata_d = BUS_W'(prio_q[i]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  AST_CFG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cfg_hit) |=> (bus_rdata == BUS_W'(PRIO_W))); // R2
  AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && src_hit && (prio_d[word_sel - 1'b1] == MASK_CODE))
      |=> (bus_rdata == 32'h0000_00FF)); // R4
  AST_RDATA_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[BUS_W-1:ARCH_PRIO_W] == '0)); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(bus_rdata)); // R9
endmodule

// File: rtl/irq_src_arb.sv
module irq_src_arb #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        irq_in,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      win_valid,
  output logic [PRIO_W-1:0]         win_prio
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [PRIO_W-1:0] MASK_CODE = '1;

  // Linear chain from index 0 upward. A strict less-than keeps the
  // lower index on equal priorities.
  logic              cand_v [NUM_SRC+1];
  logic [PRIO_W-1:0] cand_p [NUM_SRC+1];
  logic [IDX_W-1:0]  cand_i [NUM_SRC+1];

  assign cand_v[0] = 1'b0;
  assign cand_p[0] = MASK_CODE;
  assign cand_i[0] = '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    logic [PRIO_W-1:0] p;
    logic              take;
    assign p    = prio_flat[i*PRIO_W +: PRIO_W];
    assign take = irq_in[i] && (p != MASK_CODE) && (!cand_v[i] || (p < cand_p[i]));
    assign cand_v[i+1] = cand_v[i] || take;
    assign cand_p[i+1] = take ? p : cand_p[i];
    assign cand_i[i+1] = take ? IDX_W'(i) : cand_i[i];
  end

  assign win_valid = cand_v[NUM_SRC];
  assign win_prio  = cand_p[NUM_SRC];

  AST_WIN_ASSERTED: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> irq_in[cand_i[NUM_SRC]]); // R6
  AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (prio_flat[cand_i[NUM_SRC]*PRIO_W +: PRIO_W] != MASK_CODE)); // R6
endmodule

// File: rtl/irq_src_out.sv
module irq_src_out
  import irq_src_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   win_valid,
  input  logic [PRIO_W-1:0]      win_prio,
  output logic                   irq_req,
  output logic [ARCH_PRIO_W-1:0] irq_prio
);
  localparam logic [PRIO_W-1:0] MASK_CODE = '1;

  logic                   req_d;
  logic                   req_q;
  logic [ARCH_PRIO_W-1:0] prio_d;
  logic [ARCH_PRIO_W-1:0] prio_q;
  logic                   upd_en;

  always_comb begin
    req_d  = win_valid;
    prio_d = win_valid ? ARCH_PRIO_W'(win_prio) : PRIO_NONE;
    upd_en = (req_d != req_q) || (prio_d != prio_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      prio_q <= PRIO_NONE;
    end else if (upd_en) begin
      req_q  <= req_d;
      prio_q <= prio_d;
    end
  end

  assign irq_req  = req_q;
  assign irq_prio = prio_q;

  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_prio == PRIO_NONE)); // R8
  AST_REQ_PRIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_prio < ARCH_PRIO_W'(MASK_CODE))); // R7
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SRC-1:0]     irq_in,
  input  logic                   bus_en,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [BUS_W-1:0]       bus_wdata,
  output logic [BUS_W-1:0]       bus_rdata,
  output logic                   irq_req,
  output logic [ARCH_PRIO_W-1:0] irq_prio
);
  logic                      rst_meta_n;
  logic                      rst_sync_n;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                      win_valid;
  logic [PRIO_W-1:0]         win_prio;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  irq_src_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .prio_flat (prio_flat)
  );

  irq_src_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .irq_in    (irq_in),
    .prio_flat (prio_flat),
    .win_valid (win_valid),
    .win_prio  (win_prio)
  );

  irq_src_out #(.PRIO_W(PRIO_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .win_valid (win_valid),
    .win_prio  (win_prio),
    .irq_req   (irq_req),
    .irq_prio  (irq_prio)
  );

  AST_REQ_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req |-> $past(|irq_in)); // R6
endmodule

// File: tb/irq_source_ctrl_bench.sv
module irq_source_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 16;
  localparam int AW   = 8;
  localparam int NVEC = 10;

  // Each entry: [31:16] irq_in, [15:8] expected irq_req, [7:0] expected irq_prio.
  // Table priorities: s0=5 s1=2 s2=masked s3=2 s4=0 s5=6, others masked.
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0000, 8'h00, 8'hFF},
    {16'h0001, 8'h01, 8'h05},
    {16'h0003, 8'h01, 8'h02},
    {16'h0004, 8'h00, 8'hFF},
    {16'h000A, 8'h01, 8'h02},
    {16'h0013, 8'h01, 8'h00},
    {16'h0020, 8'h01, 8'h06},
    {16'h0025, 8'h01, 8'h05},
    {16'h8000, 8'h00, 8'hFF},
    {16'hFFFF, 8'h01, 8'h00}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] irq_in;
  logic            bus_en;
  logic            bus_we;
  logic [AW-1:0]   bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic            irq_req;
  logic [7:0]      irq_prio;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_source_ctrl #(.NUM_SRC(NSRC), .PRIO_W(3), .ADDR_W(AW)) u_irq_source_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_prio(irq_prio)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_in(input logic [NSRC-1:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    rst_n = 1'b0; irq_in = '0; bus_en = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq_req after reset", 32'(irq_req), 32'h0);
    chk("R1 irq_prio after reset", 32'(irq_prio), 32'hFF);
    bus_read(8'h04, rd);  chk("R1 src0 masked after reset", rd, 32'hFF);
    bus_read(8'h40, rd);  chk("R1 src15 masked after reset", rd, 32'hFF);
    set_in('1);
    chk("R1 no request with all masked", 32'(irq_req), 32'h0);
    set_in('0);

    // R2 configuration word
    bus_read(8'h00, rd);  chk("R2 config reads PRIO_W", rd, 32'h3);
    bus_write(8'h00, 32'hFFFF_FF55);
    bus_read(8'h00, rd);  chk("R2 config write ignored", rd, 32'h3);

    // R3 / R5 storage and truncation
    bus_write(8'h04, 32'h0000_00F5);
    bus_read(8'h04, rd);  chk("R5 upper write bits ignored", rd, 32'h5);
    bus_write(8'h08, 32'h2);
    bus_read(8'h08, rd);  chk("R3 src1 stores 2", rd, 32'h2);

    // R4 masking through all-ones low bits
    bus_write(8'h0C, 32'h0000_0007);
    bus_read(8'h0C, rd);  chk("R4 src2 masked reads FF", rd, 32'hFF);

    // R9 out-of-range offset
    bus_write(8'h44, 32'h1);
    bus_read(8'h44, rd);  chk("R9 out-of-range reads zero", rd, 32'h0);
    bus_read(8'h40, rd);  chk("R9 write past end leaves src15", rd, 32'hFF);

    // remaining table priorities
    bus_write(8'h10, 32'h2);
    bus_write(8'h14, 32'h0);
    bus_write(8'h18, 32'h6);
    bus_read(8'h14, rd);  chk("R3 src4 stores 0", rd, 32'h0);

    // R9 read data holds without a new read
    held = bus_rdata;
    repeat (3) @(negedge clk);
    chk("R9 rdata holds", bus_rdata, held);

    // R6 R7 R8 arbitration table
    for (int i = 0; i < NVEC; i++) begin
      set_in(VEC[i][31:16]);
      chk($sformatf("R6 vec%0d irq_req", i), 32'(irq_req), 32'(VEC[i][15:8]));
      chk($sformatf("R7 R8 vec%0d irq_prio", i), 32'(irq_prio), 32'(VEC[i][7:0]));
    end

    // R6 one-cycle latency: output must update at the first edge
    @(negedge clk);
    irq_in = 16'h0001;
    @(negedge clk);
    chk("R6 latency one cycle req", 32'(irq_req), 32'h1);
    chk("R6 latency one cycle prio", 32'(irq_prio), 32'h5);

    // R10 masking a live source at run time
    set_in(16'h0013);
    chk("R10 src4 wins", 32'(irq_prio), 32'h0);
    bus_write(8'h14, 32'h0000_000F);
    @(negedge clk);
    chk("R10 after masking src4", 32'(irq_prio), 32'h2);
    set_in(16'h0001);
    chk("R10 input drop", 32'(irq_prio), 32'h5);
    set_in(16'h0000);
    chk("R10 all dropped req", 32'(irq_req), 32'h0);
    chk("R8 idle prio", 32'(irq_prio), 32'hFF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule